// File: doc/BRIEF.md
# Pipelined Register Scoreboard

This block records the destination register of every instruction that has left decode and has not yet written back. Decode shows it three register indices each cycle: the first source, the second source and the destination of the instruction it wants to issue. The block answers combinationally whether any of them matches an outstanding write. Any match means the instruction must wait. Decode raises `stall` on any such hit.

Outstanding entries form an in-order ring queue of `DEPTH` slots. An instruction that clears the hazard check is inserted at the tail. Each writeback retires the oldest entry, and it does so only after the register file has taken the value. Squashed instructions also produce a writeback, but with no destination. Their entries therefore leave the queue the same way.

Within a cycle, removal is applied first. A search never sees the entry being retired, and an insert may use the slot being freed. An insert in a cycle becomes visible to searches only from the next cycle. Each index carries a valid flag. Invalid queries never match, and an inserted invalid destination holds a slot without ever matching.

Top module: `hzd_scoreboard`

## Requirements
- R1: A synchronous active-high `rst` empties the scoreboard. After it, every hit output is 0 and `ins_rdy` is 1.
- R2: `src1_hit` (or `src2_hit`) is 1 when its query valid is 1 and a visible held entry has valid 1 and an equal index.
- R3: `dst_hit` follows the same matching rule for the destination query.
- R4: A query whose valid input is 0 never produces a hit, whatever its index.
- R5: Inserting with `ins_vld` = 0 takes a queue slot, but that entry never matches any query.
- R6: An insert accepted in a cycle does not affect that cycle's searches. It matches from the next cycle on.
- R7: `rem_en` retires the oldest held entry, and only that one. It is legal only when the scoreboard holds at least one entry.
- R8: In a cycle with `rem_en` = 1, the oldest entry is already excluded from all three searches.
- R9: `ins_rdy` is 0 when all `DEPTH` slots are held and `rem_en` is 0. Otherwise it is 1. An insert while `ins_rdy` = 0 is dropped and never matches.
- R10: `stall` is 1 exactly when at least one of the three hit outputs is 1.
- R11: With `DEPTH` = 1 the scoreboard fills after one insert. It also accepts an insert in the same cycle as the remove of its only entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_en | input | 1 | Insert request from issue |
| ins_vld | input | 1 | Destination index valid for the insert |
| ins_idx | input | IDX_W | Destination register index to insert |
| ins_rdy | output | 1 | A slot is free this cycle (counting a same-cycle remove) |
| rem_en | input | 1 | Retire the oldest entry (one per writeback) |
| src1_vld | input | 1 | First source query valid |
| src1_idx | input | IDX_W | First source register index |
| src2_vld | input | 1 | Second source query valid |
| src2_idx | input | IDX_W | Second source register index |
| dst_vld | input | 1 | Destination query valid |
| dst_idx | input | IDX_W | Destination register index |
| src1_hit | output | 1 | First source matches an outstanding write |
| src2_hit | output | 1 | Second source matches an outstanding write |
| dst_hit | output | 1 | Destination matches an outstanding write |
| stall | output | 1 | OR of the three hit outputs |

## Verification
A writeback retirement and an issue insert can fall in the same cycle. So can a retirement and the three searches. The bench provokes both overlaps with directed sequences: it retires from a full queue while inserting, and it searches for the exact index being retired. It also lets random traffic raise `rem_en` and `ins_en` together freely. Each cycle, a queue model in the bench pops before it pushes. It computes the expected hits over the entries that remain after the pop, and expects readiness from occupancy and the same-cycle remove. Those values are compared with the block's outputs.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int SB_DEF_DEPTH = 4;
    localparam int SB_DEF_IDX_W = 5;
    localparam int SB_NUM_QRY   = 3;

    // query slot numbering used by the top and its match units
    localparam int QRY_SRC1 = 0;
    localparam int QRY_SRC2 = 1;
    localparam int QRY_DST  = 2;

    typedef enum logic [1:0] {
        Q_HOLD = 2'b00,
        Q_PUSH = 2'b01,
        Q_POP  = 2'b10,
        Q_BOTH = 2'b11
    } q_op_e;

    function automatic q_op_e q_op(input logic push, input logic pop);
        q_op_e r;
        case ({pop, push})
            2'b01:   r = Q_PUSH;
            2'b10:   r = Q_POP;
            2'b11:   r = Q_BOTH;
            default: r = Q_HOLD;
        endcase
        return r;
    endfunction

    // offset of a slot from the head in a ring of the given depth
    function automatic int ring_offset(input int slot, input int head, input int depth);
        int o;
        if (slot >= head) o = slot - head;
        else              o = slot + depth - head;
        return o;
    endfunction

endpackage

// File: rtl/sb_match_unit.sv
module sb_match_unit #(
    parameter int DEPTH = sb_pkg::SB_DEF_DEPTH,
    parameter int IDX_W = sb_pkg::SB_DEF_IDX_W
) (
    input  logic                        q_vld,
    input  logic [IDX_W-1:0]            q_idx,
    input  logic [DEPTH-1:0]            slot_vld,
    input  logic [DEPTH-1:0][IDX_W-1:0] slot_idx,
    input  logic [DEPTH-1:0]            visible,
    output logic                        hit
);

    logic [DEPTH-1:0] slot_hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign slot_hit[i] = visible[i] && slot_vld[i] && (slot_idx[i] == q_idx);
    end

    assign hit = q_vld && (|slot_hit);

endmodule

// File: rtl/sb_visibility.sv
module sb_visibility #(
    parameter int DEPTH = sb_pkg::SB_DEF_DEPTH,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [PTR_W-1:0] head_ptr,
    input  logic [CNT_W-1:0] occ_cnt,
    input  logic             pop,
    output logic [DEPTH-1:0] visible
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        int ofs;
        always_comb begin
            ofs        = sb_pkg::ring_offset(i, int'(head_ptr), DEPTH);
            // a slot counts if it is held, minus the head being retired now
            visible[i] = (ofs < int'(occ_cnt)) && !(pop && (ofs == 0));
        end
    end

endmodule

// File: rtl/sb_queue_store.sv
module sb_queue_store #(
    parameter int DEPTH = sb_pkg::SB_DEF_DEPTH,
    parameter int IDX_W = sb_pkg::SB_DEF_IDX_W,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        push,
    input  logic                        push_vld,
    input  logic [IDX_W-1:0]            push_idx,
    input  logic                        pop,
    output logic [DEPTH-1:0]            slot_vld,
    output logic [DEPTH-1:0][IDX_W-1:0] slot_idx,
    output logic [PTR_W-1:0]            head_ptr,
    output logic [CNT_W-1:0]            occ_cnt
);
    import sb_pkg::*;

    logic [PTR_W-1:0] tail_ptr;
    q_op_e            op;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + PTR_W'(1);
    endfunction

    assign op = q_op(push, pop);

    always_ff @(posedge clk) begin
        if (rst) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            occ_cnt  <= '0;
        end else begin
            case (op)
                Q_PUSH: begin
                    tail_ptr <= ptr_inc(tail_ptr);
                    occ_cnt  <= occ_cnt + CNT_W'(1);
                end
                Q_POP: begin
                    head_ptr <= ptr_inc(head_ptr);
                    occ_cnt  <= occ_cnt - CNT_W'(1);
                end
                Q_BOTH: begin
                    head_ptr <= ptr_inc(head_ptr);
                    tail_ptr <= ptr_inc(tail_ptr);
                end
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_vld[i] <= 1'b0;
                slot_idx[i] <= '0;
            end else if (push && (tail_ptr == PTR_W'(i))) begin
                slot_vld[i] <= push_vld;
                slot_idx[i] <= push_idx;
            end
        end
    end

endmodule

// File: rtl/hzd_scoreboard.sv
module hzd_scoreboard #(
    parameter int DEPTH = sb_pkg::SB_DEF_DEPTH,
    parameter int IDX_W = sb_pkg::SB_DEF_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_en,
    input  logic             ins_vld,
    input  logic [IDX_W-1:0] ins_idx,
    output logic             ins_rdy,
    input  logic             rem_en,
    input  logic             src1_vld,
    input  logic [IDX_W-1:0] src1_idx,
    input  logic             src2_vld,
    input  logic [IDX_W-1:0] src2_idx,
    input  logic             dst_vld,
    input  logic [IDX_W-1:0] dst_idx,
    output logic             src1_hit,
    output logic             src2_hit,
    output logic             dst_hit,
    output logic             stall
);
    import sb_pkg::*;

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0]            slot_vld;
    logic [DEPTH-1:0][IDX_W-1:0] slot_idx;
    logic [PTR_W-1:0]            head_ptr;
    logic [CNT_W-1:0]            occ_cnt;
    logic [DEPTH-1:0]            visible;
    logic                        rem_fire;
    logic                        ins_fire;

    logic [SB_NUM_QRY-1:0]            q_vld;
    logic [SB_NUM_QRY-1:0][IDX_W-1:0] q_idx;
    logic [SB_NUM_QRY-1:0]            q_hit;

    // removal comes first: it may free the slot an insert needs
    assign rem_fire = rem_en && (occ_cnt != '0);
    assign ins_rdy  = (occ_cnt != CNT_W'(DEPTH)) || rem_fire;
    assign ins_fire = ins_en && ins_rdy;

    sb_queue_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .push     (ins_fire),
        .push_vld (ins_vld),
        .push_idx (ins_idx),
        .pop      (rem_fire),
        .slot_vld (slot_vld),
        .slot_idx (slot_idx),
        .head_ptr (head_ptr),
        .occ_cnt  (occ_cnt)
    );

    sb_visibility #(.DEPTH(DEPTH)) u_vis (
        .head_ptr (head_ptr),
        .occ_cnt  (occ_cnt),
        .pop      (rem_fire),
        .visible  (visible)
    );

    assign q_vld[QRY_SRC1] = src1_vld;
    assign q_idx[QRY_SRC1] = src1_idx;
    assign q_vld[QRY_SRC2] = src2_vld;
    assign q_idx[QRY_SRC2] = src2_idx;
    assign q_vld[QRY_DST]  = dst_vld;
    assign q_idx[QRY_DST]  = dst_idx;

    for (genvar q = 0; q < SB_NUM_QRY; q++) begin : g_qry
        sb_match_unit #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_match (
            .q_vld    (q_vld[q]),
            .q_idx    (q_idx[q]),
            .slot_vld (slot_vld),
            .slot_idx (slot_idx),
            .visible  (visible),
            .hit      (q_hit[q])
        );
    end

    assign src1_hit = q_hit[QRY_SRC1];
    assign src2_hit = q_hit[QRY_SRC2];
    assign dst_hit  = q_hit[QRY_DST];
    assign stall    = |q_hit;

endmodule

// File: rtl/hzd_scoreboard_chk.sv
module hzd_scoreboard_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             ins_en,
    input logic             ins_rdy,
    input logic             rem_en,
    input logic             src1_vld,
    input logic             src2_vld,
    input logic             dst_vld,
    input logic             src1_hit,
    input logic             src2_hit,
    input logic             dst_hit,
    input logic             stall,
    input logic [CNT_W-1:0] occ_cnt
);

    // R1
    a_r1_reset_empty: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (occ_cnt == '0));

    // R9
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        occ_cnt <= CNT_W'(DEPTH));

    // R9
    a_r9_full_refuse: assert property (@(posedge clk) disable iff (rst)
        ((occ_cnt == CNT_W'(DEPTH)) && !rem_en) |-> !ins_rdy);

    // R7: retiring from an empty scoreboard is illegal
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
        rem_en |-> (occ_cnt != '0));

    // R7
    a_r7_count_drop: assert property (@(posedge clk) disable iff (rst)
        (rem_en && (occ_cnt != '0) && !(ins_en && ins_rdy)) |=> (occ_cnt == $past(occ_cnt) - CNT_W'(1)));

    // R4
    a_r4_invalid_no_hit: assert property (@(posedge clk) disable iff (rst)
        (!src1_vld |-> !src1_hit) and (!src2_vld |-> !src2_hit) and (!dst_vld |-> !dst_hit));

    // R2
    a_r2_empty_no_stall: assert property (@(posedge clk) disable iff (rst)
        (occ_cnt == '0) |-> !stall);

endmodule

bind hzd_scoreboard hzd_scoreboard_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ins_en   (ins_en),
    .ins_rdy  (ins_rdy),
    .rem_en   (rem_en),
    .src1_vld (src1_vld),
    .src2_vld (src2_vld),
    .dst_vld  (dst_vld),
    .src1_hit (src1_hit),
    .src2_hit (src2_hit),
    .dst_hit  (dst_hit),
    .stall    (stall),
    .occ_cnt  (occ_cnt)
);

// File: tb/hzd_scoreboard_bench.sv
module hzd_scoreboard_bench;

    localparam int DEPTH    = 4;
    localparam int IDX_W    = 5;
    localparam int HALF     = 10;
    localparam int WATCHDOG = 150000;
    localparam int NRAND    = 4000;

    logic clk = 1'b0;
    always #(HALF) clk = ~clk;

    logic             rst;
    logic             ins_en, ins_vld, rem_en;
    logic [IDX_W-1:0] ins_idx;
    logic             src1_vld, src2_vld, dst_vld;
    logic [IDX_W-1:0] src1_idx, src2_idx, dst_idx;
    logic             ins_rdy, src1_hit, src2_hit, dst_hit, stall;

    // single-entry instance
    logic             e_ins_en, e_ins_vld, e_rem_en, e_q_vld;
    logic [IDX_W-1:0] e_ins_idx, e_q_idx;
    logic             e_rdy, e_h1, e_h2, e_hd, e_stall;

    hzd_scoreboard #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_hzd_scoreboard (
        .clk(clk), .rst(rst),
        .ins_en(ins_en), .ins_vld(ins_vld), .ins_idx(ins_idx), .ins_rdy(ins_rdy),
        .rem_en(rem_en),
        .src1_vld(src1_vld), .src1_idx(src1_idx),
        .src2_vld(src2_vld), .src2_idx(src2_idx),
        .dst_vld(dst_vld), .dst_idx(dst_idx),
        .src1_hit(src1_hit), .src2_hit(src2_hit), .dst_hit(dst_hit), .stall(stall)
    );

    hzd_scoreboard #(.DEPTH(1), .IDX_W(IDX_W)) u_hzd_scoreboard_d1 (
        .clk(clk), .rst(rst),
        .ins_en(e_ins_en), .ins_vld(e_ins_vld), .ins_idx(e_ins_idx), .ins_rdy(e_rdy),
        .rem_en(e_rem_en),
        .src1_vld(e_q_vld), .src1_idx(e_q_idx),
        .src2_vld(1'b0), .src2_idx(e_q_idx),
        .dst_vld(1'b0), .dst_idx(e_q_idx),
        .src1_hit(e_h1), .src2_hit(e_h2), .dst_hit(e_hd), .stall(e_stall)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [IDX_W:0] mq[$];   // bit IDX_W = valid flag, oldest first

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_hit(input logic qv, input logic [IDX_W-1:0] qi, input logic pop);
        logic h = 1'b0;
        int first = (pop && mq.size() > 0) ? 1 : 0;
        for (int k = first; k < mq.size(); k++)
            if (qv && mq[k][IDX_W] && mq[k][IDX_W-1:0] == qi) h = 1'b1;
        return h;
    endfunction

    function automatic logic exp_rdy();
        return (mq.size() < DEPTH) || (rem_en && mq.size() > 0);
    endfunction

    // compare all outputs of the main instance against the model
    task automatic check_model();
        logic e1, e2, ed;
        #1;
        e1 = exp_hit(src1_vld, src1_idx, rem_en);
        e2 = exp_hit(src2_vld, src2_idx, rem_en);
        ed = exp_hit(dst_vld, dst_idx, rem_en);
        chk("R2 src1", src1_hit, e1);
        chk("R2 src2", src2_hit, e2);
        chk("R3 dst", dst_hit, ed);
        chk("R9 ready", ins_rdy, exp_rdy());
        chk("R10 stall", stall, e1 | e2 | ed);
    endtask

    // clock edge: model pops first, then pushes
    task automatic advance();
        logic rdy_now;
        rdy_now = exp_rdy();
        @(posedge clk);
        if (rst) mq.delete();
        else begin
            if (rem_en && mq.size() > 0) void'(mq.pop_front());
            if (ins_en && rdy_now) mq.push_back({ins_vld, ins_idx});
        end
        @(negedge clk);
    endtask

    task automatic set_in(input logic ie, input logic iv, input int ii, input logic re);
        ins_en = ie; ins_vld = iv; ins_idx = IDX_W'(ii); rem_en = re;
    endtask

    task automatic set_q(input logic v1, input int i1, input logic v2, input int i2,
                         input logic vd, input int id);
        src1_vld = v1; src1_idx = IDX_W'(i1);
        src2_vld = v2; src2_idx = IDX_W'(i2);
        dst_vld  = vd; dst_idx  = IDX_W'(id);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd4711);
        rst = 1'b1;
        set_in(0, 0, 0, 0); set_q(0, 0, 0, 0, 0, 0);
        e_ins_en = 0; e_ins_vld = 0; e_ins_idx = '0; e_rem_en = 0; e_q_vld = 0; e_q_idx = '0;
        @(negedge clk); advance(); advance();
        rst = 1'b0;

        // R1: reset state
        set_q(1, 0, 1, 0, 1, 0);
        #1;
        chk("R1 src1 after reset", src1_hit, 1'b0);
        chk("R1 dst after reset", dst_hit, 1'b0);
        chk("R1 ready after reset", ins_rdy, 1'b1);
        chk("R1 d1 ready after reset", e_rdy, 1'b1);

        // R6: same-cycle insert not seen
        set_in(1, 1, 5, 0); set_q(1, 5, 0, 0, 1, 5);
        #1;
        chk("R6 insert not seen same cycle", stall, 1'b0);
        check_model(); advance();
        // R2 / R3 / R4 next cycle
        set_in(0, 0, 0, 0); set_q(1, 5, 0, 5, 1, 5);
        #1;
        chk("R2 src1 sees entry", src1_hit, 1'b1);
        chk("R3 dst sees entry", dst_hit, 1'b1);
        chk("R4 invalid query", src2_hit, 1'b0);
        check_model(); advance();

        // R5: invalid destination holds a slot
        set_in(1, 0, 6, 0); check_model(); advance();
        set_in(1, 1, 7, 0); set_q(1, 6, 1, 6, 1, 6);
        #1;
        chk("R5 invalid entry never matches", stall, 1'b0);
        check_model(); advance();
        set_in(1, 1, 1, 0); check_model(); advance();
        // full now: 5, (inv 6), 7, 1
        set_in(1, 1, 2, 0); set_q(0, 0, 0, 0, 0, 0);
        #1;
        chk("R9 full refuses", ins_rdy, 1'b0);
        check_model(); advance();
        set_in(0, 0, 0, 0); set_q(1, 2, 0, 0, 0, 0);
        #1;
        chk("R9 refused insert dropped", src1_hit, 1'b0);
        check_model(); advance();

        // R8 / R9: remove and insert together while full
        set_in(1, 1, 2, 1); set_q(1, 5, 1, 7, 1, 2);
        #1;
        chk("R8 retiring head hidden", src1_hit, 1'b0);
        chk("R8 younger still seen", src2_hit, 1'b1);
        chk("R9 ready with remove", ins_rdy, 1'b1);
        check_model(); advance();
        set_in(0, 0, 0, 1); set_q(1, 2, 1, 7, 1, 5);
        #1;
        chk("R7 new entry held", src1_hit, 1'b1);
        chk("R7 oldest only retired", src2_hit, 1'b1);
        chk("R7 first entry gone", dst_hit, 1'b0);
        check_model(); advance();

        // R11: single-entry instance
        e_ins_en = 1; e_ins_vld = 1; e_ins_idx = 5'd3;
        @(posedge clk); @(negedge clk);
        e_ins_en = 0; e_q_vld = 1; e_q_idx = 5'd3;
        #1;
        chk("R11 d1 holds entry", e_h1, 1'b1);
        chk("R11 d1 full", e_rdy, 1'b0);
        e_rem_en = 1; e_ins_en = 1; e_ins_idx = 5'd4;
        #1;
        chk("R11 d1 retire hides entry", e_h1, 1'b0);
        chk("R11 d1 ready on remove", e_rdy, 1'b1);
        @(posedge clk); @(negedge clk);
        e_rem_en = 0; e_ins_en = 0; e_q_idx = 5'd4;
        #1;
        chk("R11 d1 swap inserted", e_stall, 1'b1);

        // R1: reset mid-run empties
        rst = 1'b1; set_in(0, 0, 0, 0); advance(); rst = 1'b0;
        set_q(1, 7, 1, 2, 1, 1);
        #1;
        chk("R1 reset empties", stall, 1'b0);
        chk("R1 ready after mid reset", ins_rdy, 1'b1);

        // random traffic
        for (int c = 0; c < NRAND; c++) begin
            logic re;
            re = (mq.size() > 0) && (($urandom % 3) == 0 || mq.size() == DEPTH && ($urandom % 2) == 0);
            set_in(($urandom % 3) != 0, ($urandom % 8) != 0, $urandom % 8, re);
            set_q(($urandom % 8) != 0, $urandom % 8, ($urandom % 8) != 0, $urandom % 8,
                  ($urandom % 8) != 0, $urandom % 8);
            check_model();
            advance();
        end

        summary();
        $finish;
    end

endmodule